// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames out of a shared word memory under the control of a ring of transmit descriptors. Host software owns the ring. It fills a buffer, writes a descriptor and sets the ownership bit last. The engine then examines the current descriptor, either on a transmit-demand pulse or on its own periodic poll. If the device owns that descriptor, the engine streams the buffer's bytes to a byte output. It then writes back a status word and a flag byte with ownership cleared, moves to the next ring slot and pulses a transmit interrupt. It keeps scanning until it meets a descriptor it does not own.

Each descriptor is four consecutive 16-bit words:

| Word | Contents |
|------|----------|
| +0 | Low 16 bits of the buffer byte address |
| +1 | Flag byte in bits 15:8, high address byte in bits 7:0 |
| +2 | Two's complement of the byte count |
| +3 | Status word |

A frame may span several buffers, linked by start-of-packet and end-of-packet marks. Collision outcomes come from a stub input and are folded into the flag byte of the buffer that ends the frame. An underflow error turns the transmitter off until the next initialisation.

Top module: `txdesc_ring_engine`

## Requirements
- R1: After reset the transmitter is off. The engine drives no memory read, no memory write, no byte and no interrupt, and a transmit demand has no effect until `init_req` is pulsed.
- R2: In idle with the transmitter on, a `tx_demand` pulse makes the engine read the current descriptor's flag word (address `ring_base` + 4·index + 1) in the cycle after the pulse. After `init_req` the index is 0.
- R3: With no demand, the engine polls the current descriptor every `POLL_CYCLES` cycles and processes it if the device owns it.
- R4: A descriptor whose flag bit 7 (ownership) is 0 ends the scan. No byte is sent and no memory word is written, unless R9 applies.
- R5: For an owned descriptor, the engine sends N bytes starting at the buffer byte address, where N is the two's complement of word +2. Byte address 2k is bits 15:8 of memory word k, and byte address 2k+1 is bits 7:0.
- R6: When a descriptor finishes, the engine writes the status word (+3) and then the flag word (+1). The flag word has bit 15 (ownership) cleared and keeps its start mark (bit 9), end mark (bit 8) and high address byte. `tx_irq` pulses for one cycle after each flag-word write.
- R7: On a buffer with the end mark, `col_outcome` sets flag bits as follows: 1 sets bit 3 (one retry); 2 sets bit 4 (several retries); 3 sets bit 6 (error) and status bit 10 (failed after retries). `deferred_in` sets flag bit 2.
- R8: The ring size is 2^L entries, where L is `ring_len` bits 7:5 as captured at init. The index advances after every finished descriptor and wraps to 0 after 2^L − 1. The scan continues into the next slot.
- R9: When a buffer without the end mark is followed by a descriptor the device does not own, the engine rewrites the earlier descriptor. It sets flag bit 6 (error) and status bit 15 (buffer error), then pulses `tx_irq` again.
- R10: If `underflow_in` is high while a byte is sent, the engine still sends that byte, then closes the descriptor with flag bit 6 and status bit 14 set. It then ignores demands and polls until the next `init_req`.
- R11: A descriptor with a byte count of 0 sends no bytes and is still written back as finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Initialise: index to 0, latch ring base and size, transmitter on |
| ring_base | input | AW | Word address of descriptor 0 |
| ring_len | input | 8 | Ring size byte; bits 7:5 hold log2 of the entry count |
| tx_demand | input | 1 | Transmit demand pulse |
| col_outcome | input | 2 | Stub collision outcome: 0 clean, 1 one retry, 2 several retries, 3 failed |
| deferred_in | input | 1 | Stub: the frame was deferred |
| underflow_in | input | 1 | Stub: data arrived too late during streaming |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Read strobe; data returns on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| tx_valid | output | 1 | Byte output valid |
| tx_byte | output | 8 | Byte output |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |

## Verification
The assertions check the following on every cycle:
- no read and write happen together;
- every output byte follows a memory read;
- every flag-word write clears ownership and comes straight after a status write;
- every interrupt follows a flag-word write;
- nothing is read after an underflow stop;
- the ring index stays below the configured ring size.

Only the bench scenarios can show the rest: the byte values and their order, the exact written-back words for each collision code, wrapping across the ring, poll timing, the buffer-error repair of a broken chain and re-enabling after init.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RDFLAG, S_CHKF, S_RDLEN, S_GETLEN, S_FETCH, S_EMIT,
    S_WBMISC, S_WBFLAG, S_BERR1, S_BERR2
  } txr_state_e;

  localparam int F_ENP = 0, F_STP = 1, F_DEF = 2, F_ONE = 3, F_MORE = 4, F_ERR = 6, F_OWN = 7;
  localparam int M_RTRY = 10, M_UFLO = 14, M_BUFF = 15;
  localparam logic [1:0] COL_ONE = 2'd1, COL_MORE = 2'd2, COL_FAIL = 2'd3;

  // byte count held negated in the descriptor
  function automatic logic [15:0] byte_count(input logic [15:0] w);
    return ~w + 16'd1;
  endfunction

  function automatic logic [15:0] desc_word(input logic [15:0] base, input logic [6:0] idx,
                                            input logic [1:0] w);
    return base + {7'd0, idx, 2'b00} + {14'd0, w};
  endfunction

  function automatic logic [6:0] next_idx(input logic [6:0] idx, input logic [2:0] lg);
    logic [7:0] mask;
    mask = (8'd1 << lg) - 8'd1;
    return (idx + 7'd1) & mask[6:0];
  endfunction

  function automatic logic [7:0] done_flag(input logic [7:0] f, input logic uflo,
                                           input logic [1:0] col, input logic dfr);
    logic [7:0] r;
    r = f & 8'h03;
    if (uflo) r[F_ERR] = 1'b1;
    else if (f[F_ENP]) begin
      r[F_DEF]  = dfr;
      r[F_ONE]  = (col == COL_ONE);
      r[F_MORE] = (col == COL_MORE);
      r[F_ERR]  = (col == COL_FAIL);
    end
    return r;
  endfunction

  function automatic logic [15:0] done_misc(input logic enp, input logic uflo, input logic [1:0] col);
    logic [15:0] r;
    r = 16'd0;
    r[M_UFLO] = uflo;
    r[M_RTRY] = enp && !uflo && (col == COL_FAIL);
    return r;
  endfunction
endpackage

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
  parameter int PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(PERIOD + 1);
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr
  import txr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic [2:0] log2_in,
  input  logic       adv,
  output logic [6:0] idx,
  output logic [2:0] log2_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      log2_q <= '0;
    end else if (init) begin
      idx    <= '0;
      log2_q <= log2_in;
    end else if (adv) begin
      idx <= next_idx(idx, log2_q);
    end
  end
endmodule

// File: rtl/txdesc_ring_engine.sv
module txdesc_ring_engine
  import txr_pkg::*;
#(
  parameter int AW          = 10,
  parameter int POLL_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_req,
  input  logic [AW-1:0] ring_base,
  input  logic [7:0]    ring_len,
  input  logic          tx_demand,
  input  logic [1:0]    col_outcome,
  input  logic          deferred_in,
  input  logic          underflow_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  output logic          tx_irq
);
  localparam logic [15:0] BUFF_WORD = 16'd1 << M_BUFF;
  localparam logic [15:0] ERR_IN_FW = 16'd1 << (8 + F_ERR);

  txr_state_e    state;
  logic          tx_on, in_frame, uflo_r;
  logic [AW-1:0] base_r;
  logic [7:0]    flag, hi;
  logic [15:0]   ptr, cnt, fw_r, prev_fw;
  logic [6:0]    idx, prev_idx, desc_idx;
  logic [2:0]    lg;
  logic          poll_tick, adv;

  // named events for the checker
  logic ev_flag_wr, ev_misc_wr, ev_uflo_stop;
  assign ev_flag_wr   = (state == S_WBFLAG) || (state == S_BERR2);
  assign ev_misc_wr   = (state == S_WBMISC) || (state == S_BERR1);
  assign ev_uflo_stop = (state == S_WBFLAG) && uflo_r;
  assign adv          = (state == S_WBFLAG);

  txr_ring_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .init(init_req), .log2_in(ring_len[7:5]),
    .adv(adv), .idx(idx), .log2_q(lg)
  );

  txr_poll_timer #(.PERIOD(POLL_CYCLES)) u_poll (
    .clk(clk), .rst_n(rst_n), .en(tx_on), .tick(poll_tick)
  );

  function automatic logic [AW-1:0] daddr(input logic [6:0] i, input logic [1:0] w);
    return AW'(desc_word(16'(base_r), i, w));
  endfunction

  always_comb begin
    desc_idx  = (state == S_BERR1 || state == S_BERR2) ? prev_idx : idx;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    tx_valid  = 1'b0;
    tx_byte   = 8'd0;
    case (state)
      S_RDFLAG: begin mem_rd = 1'b1; mem_addr = daddr(desc_idx, 2'd1); end
      S_CHKF: if (mem_rdata[8 + F_OWN]) begin mem_rd = 1'b1; mem_addr = daddr(desc_idx, 2'd0); end
      S_RDLEN:  begin mem_rd = 1'b1; mem_addr = daddr(desc_idx, 2'd2); end
      S_FETCH:  begin mem_rd = 1'b1; mem_addr = ptr[AW:1]; end
      S_EMIT:   begin tx_valid = 1'b1; tx_byte = ptr[0] ? mem_rdata[7:0] : mem_rdata[15:8]; end
      S_WBMISC: begin
        mem_wr = 1'b1; mem_addr = daddr(desc_idx, 2'd3);
        mem_wdata = done_misc(flag[F_ENP], uflo_r, col_outcome);
      end
      S_WBFLAG: begin mem_wr = 1'b1; mem_addr = daddr(desc_idx, 2'd1); mem_wdata = fw_r; end
      S_BERR1:  begin mem_wr = 1'b1; mem_addr = daddr(desc_idx, 2'd3); mem_wdata = BUFF_WORD; end
      S_BERR2:  begin mem_wr = 1'b1; mem_addr = daddr(desc_idx, 2'd1); mem_wdata = prev_fw | ERR_IN_FW; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tx_on <= 1'b0; in_frame <= 1'b0; uflo_r <= 1'b0;
      base_r <= '0; flag <= '0; hi <= '0; ptr <= '0; cnt <= '0;
      fw_r <= '0; prev_fw <= '0; prev_idx <= '0;
    end else if (init_req) begin
      state <= S_IDLE; tx_on <= 1'b1; in_frame <= 1'b0; uflo_r <= 1'b0;
      base_r <= ring_base;
    end else begin
      case (state)
        S_IDLE:   if (tx_on && (tx_demand || poll_tick)) state <= S_RDFLAG;
        S_RDFLAG: state <= S_CHKF;
        S_CHKF: begin
          if (mem_rdata[8 + F_OWN]) begin
            flag   <= mem_rdata[15:8];
            hi     <= mem_rdata[7:0];
            uflo_r <= 1'b0;
            state  <= S_RDLEN;
          end else begin
            state <= in_frame ? S_BERR1 : S_IDLE;
          end
        end
        S_RDLEN: begin ptr <= mem_rdata; state <= S_GETLEN; end
        S_GETLEN: begin
          cnt   <= byte_count(mem_rdata);
          state <= (byte_count(mem_rdata) == 16'd0) ? S_WBMISC : S_FETCH;
        end
        S_FETCH: state <= S_EMIT;
        S_EMIT: begin
          ptr <= ptr + 16'd1;
          cnt <= cnt - 16'd1;
          if (underflow_in) begin
            uflo_r <= 1'b1;
            state  <= S_WBMISC;
          end else begin
            state <= (cnt == 16'd1) ? S_WBMISC : S_FETCH;
          end
        end
        S_WBMISC: begin
          fw_r  <= {done_flag(flag, uflo_r, col_outcome, deferred_in), hi};
          state <= S_WBFLAG;
        end
        S_WBFLAG: begin
          prev_idx <= idx;
          prev_fw  <= fw_r;
          in_frame <= !flag[F_ENP] && !uflo_r;
          if (uflo_r) begin
            tx_on <= 1'b0;
            state <= S_IDLE;
          end else begin
            state <= S_RDFLAG;
          end
        end
        S_BERR1: state <= S_BERR2;
        S_BERR2: begin in_frame <= 1'b0; state <= S_IDLE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_irq <= 1'b0;
    else tx_irq <= ev_flag_wr;
  end
endmodule

// File: rtl/txr_checker.sv
module txr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [15:0] mem_wdata,
  input logic       tx_valid,
  input logic       tx_irq,
  input logic       ev_flag_wr,
  input logic       ev_misc_wr,
  input logic       ev_uflo_stop,
  input logic [6:0] idx,
  input logic [2:0] lg
);
  // R1
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  // R5
  byte_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_valid |-> $past(mem_rd));
  // R6
  own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_flag_wr |-> (mem_wr && !mem_wdata[15]));
  // R6
  status_first_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_flag_wr |-> $past(ev_misc_wr));
  // R6
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_irq |-> $past(ev_flag_wr));
  // R10
  uflo_halt_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_uflo_stop |=> !mem_rd);
  // R8
  idx_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n) (idx >> lg) == 7'd0);
endmodule

bind txdesc_ring_engine txr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
  .tx_valid(tx_valid), .tx_irq(tx_irq), .ev_flag_wr(ev_flag_wr), .ev_misc_wr(ev_misc_wr),
  .ev_uflo_stop(ev_uflo_stop), .idx(idx), .lg(lg)
);

// File: tb/sim_txdesc_ring_engine.sv
module sim_txdesc_ring_engine;
  localparam int AW = 10;
  localparam int POLL = 200;
  localparam int RB = 'h100;

  logic clk = 1'b0, rst_n = 1'b0, init_req = 1'b0, tx_demand = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic [7:0] ring_len = '0;
  logic [1:0] col_outcome = '0;
  logic deferred_in = 1'b0, underflow_in = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, tx_valid, tx_irq;
  logic [15:0] mem_wdata, mem_rdata;
  logic [7:0] tx_byte;

  logic [15:0] mem [0:(1<<AW)-1];
  logic [7:0] exp_q[$];
  int checks = 0, failures = 0, rd_cnt = 0, wr_cnt = 0, byte_cnt = 0, irq_cnt = 0;

  always #10 clk = ~clk;

  txdesc_ring_engine #(.AW(AW), .POLL_CYCLES(POLL)) u0 (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .ring_base(ring_base), .ring_len(ring_len),
    .tx_demand(tx_demand), .col_outcome(col_outcome), .deferred_in(deferred_in),
    .underflow_in(underflow_in), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_irq(tx_irq)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) rd_cnt++;
      if (mem_wr) wr_cnt++;
      if (tx_irq) irq_cnt++;
      if (tx_valid) begin
        byte_cnt++;
        if (exp_q.size() == 0) chk("R5 unexpected byte", int'(tx_byte), -1);
        else chk("R5 byte", int'(tx_byte), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic put_byte(int ba, logic [7:0] v);
    if (ba[0]) mem[ba >> 1][7:0] = v;
    else mem[ba >> 1][15:8] = v;
  endtask

  // driver: fill buffer, queue expected bytes, write descriptor (flag word last)
  task automatic load(int di, int ba, logic [7:0] hi, logic [7:0] fl, int len, int nexp);
    for (int k = 0; k < len; k++) begin
      logic [7:0] v;
      v = 8'((ba * 3 + k * 7 + 1) & 'hff);
      put_byte(ba + k, v);
      if (k < nexp) exp_q.push_back(v);
    end
    mem[RB + 4*di + 0] = 16'(ba);
    mem[RB + 4*di + 2] = 16'(-len);
    mem[RB + 4*di + 3] = 16'h0;
    mem[RB + 4*di + 1] = {fl, hi};
  endtask

  function automatic int dw(int di, int w);
    return int'(mem[RB + 4*di + w]);
  endfunction

  task automatic demand();
    tx_demand = 1'b1;
    @(negedge clk);
    tx_demand = 1'b0;
  endtask

  task automatic do_init();
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
  endtask

  initial begin
    int r0, w0, b0, i0;
    for (int i = 0; i < (1 << AW); i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and demand ignored before init
    chk("R1 mem_rd", int'(mem_rd), 0);
    chk("R1 mem_wr", int'(mem_wr), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 tx_irq", int'(tx_irq), 0);
    demand();
    repeat (20) @(negedge clk);
    chk("R1 no reads before init", rd_cnt, 0);

    ring_base = AW'(RB);
    ring_len = 8'h60;  // 8 entries
    do_init();

    // R2 demand reads flag word of descriptor 0 next cycle
    r0 = rd_cnt; w0 = wr_cnt; b0 = byte_cnt;
    tx_demand = 1'b1;
    @(negedge clk);
    tx_demand = 1'b0;
    chk("R2 read strobe", int'(mem_rd), 1);
    chk("R2 flag address", int'(mem_addr), RB + 1);
    repeat (10) @(negedge clk);
    // R4 unowned stops the scan
    chk("R4 single read", rd_cnt - r0, 1);
    chk("R4 no writes", wr_cnt - w0, 0);
    chk("R4 no bytes", byte_cnt - b0, 0);

    // R5 R6 even-aligned frame
    i0 = irq_cnt;
    load(0, 'h400, 8'h00, 8'h83, 5, 5);
    demand();
    repeat (40) @(negedge clk);
    chk("R6 flag word d0", dw(0, 1), 'h0300);
    chk("R6 status d0", dw(0, 3), 0);
    chk("R6 irq count", irq_cnt - i0, 1);

    // R7 one retry + deferred, odd start, high byte kept
    col_outcome = 2'd1; deferred_in = 1'b1;
    load(1, 'h451, 8'h5A, 8'h83, 4, 4);
    demand();
    repeat (40) @(negedge clk);
    chk("R7 one retry flag", dw(1, 1), 'h0F5A);
    deferred_in = 1'b0;

    col_outcome = 2'd2;
    load(2, 'h480, 8'h00, 8'h83, 3, 3);
    demand();
    repeat (40) @(negedge clk);
    chk("R7 many retries flag", dw(2, 1), 'h1300);

    col_outcome = 2'd3;
    load(3, 'h4A0, 8'h00, 8'h83, 2, 2);
    demand();
    repeat (40) @(negedge clk);
    chk("R7 failed flag", dw(3, 1), 'h4300);
    chk("R7 failed status", dw(3, 3), 'h0400);
    col_outcome = 2'd0;

    // R11 zero length
    b0 = byte_cnt;
    load(4, 'h4B0, 8'h00, 8'h83, 0, 0);
    demand();
    repeat (20) @(negedge clk);
    chk("R11 zero-length flag", dw(4, 1), 'h0300);
    chk("R11 no bytes", byte_cnt - b0, 0);

    // R9 broken chain
    i0 = irq_cnt;
    load(5, 'h4C0, 8'h00, 8'h82, 3, 3);
    demand();
    repeat (40) @(negedge clk);
    chk("R9 flag error", dw(5, 1), 'h4200);
    chk("R9 buffer error", dw(5, 3), 'h8000);
    chk("R9 irq count", irq_cnt - i0, 2);

    // R8 continued scan and wrap 6 -> 7 -> 0
    load(6, 'h500, 8'h00, 8'h83, 2, 2);
    load(7, 'h520, 8'h00, 8'h83, 2, 2);
    load(0, 'h540, 8'h11, 8'h83, 2, 2);
    demand();
    repeat (80) @(negedge clk);
    chk("R8 slot 7 done", dw(7, 1), 'h0300);
    chk("R8 wrapped slot 0 done", dw(0, 1), 'h0311);

    // R3 periodic poll without demand
    load(1, 'h560, 8'h22, 8'h83, 3, 3);
    repeat (POLL + 60) @(negedge clk);
    chk("R3 polled slot 1 done", dw(1, 1), 'h0322);

    // R10 underflow
    underflow_in = 1'b1;
    load(2, 'h580, 8'h00, 8'h83, 6, 1);
    demand();
    repeat (40) @(negedge clk);
    chk("R10 underflow flag", dw(2, 1), 'h4300);
    chk("R10 underflow status", dw(2, 3), 'h4000);
    underflow_in = 1'b0;
    r0 = rd_cnt; b0 = byte_cnt;
    load(3, 'h5A0, 8'h00, 8'h83, 2, 0);
    demand();
    repeat (POLL + 60) @(negedge clk);
    chk("R10 still owned while off", dw(3, 1), 'h8300);
    chk("R10 no reads while off", rd_cnt - r0, 0);
    chk("R10 no bytes while off", byte_cnt - b0, 0);
    load(0, 'h5C0, 8'h33, 8'h83, 1, 1);
    do_init();
    demand();
    repeat (30) @(negedge clk);
    chk("R10 re-enabled by init", dw(0, 1), 'h0333);

    chk("R5 all expected bytes sent", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule